// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a supervisory down-counter that catches software which has stopped running as intended. Software must prove it is alive by sending a refresh, and that refresh is accepted only inside a window bounded at both ends. The window is set as fractions of the programmed time-out. A refresh that comes too early or too late is a fault. A counter that reaches the bottom without being refreshed is also a fault. On either fault the block raises one of two outputs: a reset held for one count period, or a single-clock non-maskable interrupt pulse.

The counter runs from a divided copy of the system clock. The divider ratios are parameters, and a 2-bit field picks one of them. The block has two start behaviours. In register-start mode it sits idle after reset and is started by the first refresh. It is configured through write-once control registers. In auto-start mode it starts counting as soon as reset is released. It takes its configuration from static option inputs and ignores the control registers. A small register bus gives access to the refresh register, the two control registers, and a status word. The status word holds the live counter and the two fault-source flags.

Top module: `winwdog`

## Requirements
- R1: Time-out field ctrl[1:0] encodes 0..3 as 1024, 4096, 8192 and 16384 count periods. The cycle in which a fault is raised lies exactly ratio × time-out clocks after the cycle in which the counter was loaded with time-out − 1.
- R2: Prescale field ctrl[3:2] encodes 0..3 as the parameter ratios DIV0..DIV3. The divider is restarted on every load and on every fault.
- R3: Window fields: start ctrl[5:4] encodes 0..3 as 25/50/75/100 % of the time-out, and end ctrl[7:6] encodes 0..3 as 75/50/25/0 %. A refresh is accepted when end ≤ counter < start, where counter is the value in the clock the refresh takes effect. Any other refresh while running sets the refresh-error flag, status bit 15.
- R4: When the counter is at 0 and a count period ends with no refresh, the underflow flag (status bit 14) is set.
- R5: If reset-control bit 0 (address 2) is 1, a fault drives the reset output high for one count period (ratio clocks), and the interrupt output stays low. If that bit is 0, the interrupt output pulses high for one clock and the reset output stays low.
- R6: Register-start mode: after reset, and after every fault, the counter reads 0 and stays there until a refresh. That refresh loads time-out − 1.
- R7: Auto-start mode (opt_auto = 1): the counter loads on the first clock after reset release, using opt_cfg and opt_rst_sel. Control-register writes are ignored and read back 0. One count period after each fault, the counter reloads and runs again on its own.
- R8: The control register (address 1) and the reset-control register (address 2) each accept one write. The first refresh also locks both. Both locks are cleared only when a watchdog reset pulse ends.
- R9: A refresh is a write of 00h and then FFh to address 0, with no other address-0 write between them. Any other pattern leaves the counter unchanged.
- R10: Status (address 3) reads {error flag, underflow flag, counter[13:0]}. Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. A new fault sets its own flag and clears the other.
- R11: Out of reset in register-start mode, both outputs are low and status, control and reset-control all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 refresh, 1 control, 2 reset-control, 3 status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| opt_auto | input | 1 | 1 selects auto-start mode |
| opt_cfg | input | 8 | Configuration used in auto-start mode, same layout as the control register |
| opt_rst_sel | input | 1 | Fault output select used in auto-start mode |
| wdt_rst_o | output | 1 | Watchdog reset request |
| wdt_nmi_o | output | 1 | Non-maskable interrupt pulse |

## Verification
The bench builds the block with a 14-bit counter and divider ratios 1, 2, 4 and 8 in place of the larger defaults. This makes every time-out code reachable, as well as the slowest ratio with the shortest time-out, within the cycle budget. Every one of the sixteen start/end window pairs is swept on the 1024-count time-out. Refreshes land one count inside and one count outside each window edge. Reset-pulse width is measured at a ratio of 4, so that a pulse of one count period can be told apart from a pulse of one clock.

// File: rtl/wdg_pkg.sv
`timescale 1ns/1ps
package wdg_pkg;
   typedef enum logic [1:0] {ST_BOOT, ST_IDLE, ST_RUN, ST_HOLD} wdg_state_e;

   typedef struct packed {
      logic [1:0] wend;
      logic [1:0] wstart;
      logic [1:0] cks;
      logic [1:0] tops;
   } wdg_cfg_t;

   localparam logic [1:0] ADDR_REFRESH = 2'd0;
   localparam logic [1:0] ADDR_CTRL    = 2'd1;
   localparam logic [1:0] ADDR_RCTRL   = 2'd2;
   localparam logic [1:0] ADDR_STATUS  = 2'd3;

   localparam logic [7:0] REFRESH_ARM  = 8'h00;
   localparam logic [7:0] REFRESH_FIRE = 8'hFF;
endpackage

// File: rtl/wdg_prescale.sv
`timescale 1ns/1ps
module wdg_prescale #(
   parameter int unsigned DIV0 = 1,
   parameter int unsigned DIV1 = 4,
   parameter int unsigned DIV2 = 16,
   parameter int unsigned DIV3 = 64,
   parameter bit          HAS_PRESCALER = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart,
   input  logic [1:0] sel,
   output logic       tick
);
   localparam int unsigned PRE_W = (DIV3 > 1) ? $clog2(DIV3) : 1;

   initial begin
      assert (DIV0 >= 1 && DIV1 >= DIV0 && DIV2 >= DIV1 && DIV3 >= DIV2)
         else $fatal(1, "divider ratios must be positive and ascending");
   end

   generate
      if (HAS_PRESCALER) begin : g_div
         logic [PRE_W-1:0] pre_q;
         logic [PRE_W-1:0] lim;

         always_comb begin
            unique case (sel)
               2'd0:    lim = PRE_W'(DIV0 - 1);
               2'd1:    lim = PRE_W'(DIV1 - 1);
               2'd2:    lim = PRE_W'(DIV2 - 1);
               default: lim = PRE_W'(DIV3 - 1);
            endcase
         end

         assign tick = (pre_q == lim);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               pre_q <= '0;
            else if (restart || tick) pre_q <= '0;
            else                      pre_q <= pre_q + 1'b1;
         end

         // R2: the divider never runs past the selected limit
         a_r2_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
            (!restart && !tick) |=> (pre_q != '0));
      end else begin : g_bypass
         assign tick = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/wdg_refresh.sv
`timescale 1ns/1ps
module wdg_refresh
   import wdg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wdata,
   output logic       refresh_p
);
   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q   <= 1'b0;
         refresh_p <= 1'b0;
      end else begin
         refresh_p <= wr_en && armed_q && (wdata == REFRESH_FIRE);
         if (wr_en) armed_q <= (wdata == REFRESH_ARM);
      end
   end

   // R9: a refresh only follows an armed write
   a_r9_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_p |-> $past(armed_q));
endmodule

// File: rtl/wdg_regs.sv
`timescale 1ns/1ps
module wdg_regs
   import wdg_pkg::*;
#(
   parameter int unsigned CNT_W  = 14,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              auto_mode,
   input  logic              refresh_p,
   input  logic              lock_clr,
   input  logic              flt_uf,
   input  logic              flt_re,
   input  logic [CNT_W-1:0]  cnt,
   output wdg_cfg_t          reg_cfg,
   output logic              reg_rsel
);
   wdg_cfg_t ctrl_q;
   logic     rsel_q, ctrl_lock_q, rctl_lock_q, uf_q, re_q;
   logic     wr_ctrl, wr_rctl, wr_stat;
   logic     unused_wdata;

   assign unused_wdata = ^bus_wdata;
   assign wr_ctrl = bus_we && bus_addr == ADDR_CTRL  && !auto_mode && !ctrl_lock_q;
   assign wr_rctl = bus_we && bus_addr == ADDR_RCTRL && !auto_mode && !rctl_lock_q;
   assign wr_stat = bus_we && bus_addr == ADDR_STATUS;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q      <= '0;
         rsel_q      <= 1'b0;
         ctrl_lock_q <= 1'b0;
         rctl_lock_q <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl_q <= wdg_cfg_t'(bus_wdata[7:0]);
         if (wr_rctl) rsel_q <= bus_wdata[0];
         if (wr_ctrl || refresh_p) ctrl_lock_q <= 1'b1;
         if (wr_rctl || refresh_p) rctl_lock_q <= 1'b1;
         if (lock_clr) begin
            ctrl_lock_q <= 1'b0;
            rctl_lock_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         uf_q <= 1'b0;
         re_q <= 1'b0;
      end else if (flt_uf) begin
         uf_q <= 1'b1;
         re_q <= 1'b0;
      end else if (flt_re) begin
         re_q <= 1'b1;
         uf_q <= 1'b0;
      end else if (wr_stat) begin
         uf_q <= uf_q & bus_wdata[CNT_W];
         re_q <= re_q & bus_wdata[CNT_W+1];
      end
   end

   always_comb begin
      unique case (bus_addr)
         ADDR_CTRL:   bus_rdata = DATA_W'(ctrl_q);
         ADDR_RCTRL:  bus_rdata = DATA_W'(rsel_q);
         ADDR_STATUS: bus_rdata = DATA_W'({re_q, uf_q, cnt});
         default:     bus_rdata = '0;
      endcase
   end

   assign reg_cfg  = ctrl_q;
   assign reg_rsel = rsel_q;

   // R8: a locked control register holds its value
   a_r8_ctrl_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_lock_q && !lock_clr) |=> $stable(ctrl_q));
   // R10: a new underflow replaces the previous source
   a_r10_replace: assert property (@(posedge clk) disable iff (!rst_n)
      flt_uf |=> (uf_q && !re_q));
endmodule

// File: rtl/wdg_core.sv
`timescale 1ns/1ps
module wdg_core
   import wdg_pkg::*;
#(
   parameter int unsigned CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             auto_mode,
   input  logic             tick,
   input  logic             refresh_p,
   input  logic [1:0]       tops_i,
   input  logic [1:0]       wstart_i,
   input  logic [1:0]       wend_i,
   input  logic             rst_sel,
   output logic [CNT_W-1:0] cnt,
   output logic             restart,
   output logic             flt_uf,
   output logic             flt_re,
   output logic             lock_clr,
   output logic             rst_o,
   output logic             nmi_o
);
   localparam int unsigned TOP_W = CNT_W + 1;
   localparam int unsigned BASE  = 1 << (CNT_W - 4);

   wdg_state_e       st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             hold_rst_q, nmi_q;
   logic [TOP_W-1:0] top_val, quarter, s_lim, e_lim, cnt_ext;
   logic             in_win, fault, ld;

   always_comb begin
      unique case (tops_i)
         2'd0:    top_val = TOP_W'(BASE);
         2'd1:    top_val = TOP_W'(BASE * 4);
         2'd2:    top_val = TOP_W'(BASE * 8);
         default: top_val = TOP_W'(BASE * 16);
      endcase
      quarter = top_val >> 2;
      unique case (wstart_i)
         2'd0:    s_lim = quarter;
         2'd1:    s_lim = quarter << 1;
         2'd2:    s_lim = quarter + (quarter << 1);
         default: s_lim = top_val;
      endcase
      unique case (wend_i)
         2'd0:    e_lim = quarter + (quarter << 1);
         2'd1:    e_lim = quarter << 1;
         2'd2:    e_lim = quarter;
         default: e_lim = '0;
      endcase
   end

   assign cnt_ext = {1'b0, cnt_q};
   assign in_win  = (cnt_ext < s_lim) && (cnt_ext >= e_lim);
   assign flt_re  = (st_q == ST_RUN) && refresh_p && !in_win;
   assign flt_uf  = (st_q == ST_RUN) && !refresh_p && tick && (cnt_q == '0);
   assign fault   = flt_re || flt_uf;
   assign ld      = ((st_q == ST_RUN)  && refresh_p && in_win) ||
                    ((st_q == ST_IDLE) && refresh_p && !auto_mode) ||
                    ((st_q == ST_BOOT) && auto_mode) ||
                    ((st_q == ST_HOLD) && tick && auto_mode);
   assign restart  = ld || fault;
   assign lock_clr = (st_q == ST_HOLD) && tick && hold_rst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_BOOT;
         cnt_q      <= '0;
         hold_rst_q <= 1'b0;
         nmi_q      <= 1'b0;
      end else begin
         nmi_q <= fault && !rst_sel;
         if (fault) begin
            st_q       <= ST_HOLD;
            cnt_q      <= '0;
            hold_rst_q <= rst_sel;
         end else if (ld) begin
            st_q  <= ST_RUN;
            cnt_q <= CNT_W'(top_val - TOP_W'(1));
         end else if (st_q == ST_RUN && tick) begin
            cnt_q <= cnt_q - 1'b1;
         end else if (st_q == ST_BOOT || (st_q == ST_HOLD && tick)) begin
            st_q <= ST_IDLE;
         end
      end
   end

   assign cnt   = cnt_q;
   assign rst_o = (st_q == ST_HOLD) && hold_rst_q;
   assign nmi_o = nmi_q;

   // R1: without a load or fault the count never rises
   a_r1_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RUN && !restart) |=> (cnt_q <= $past(cnt_q)));
   // R3: a refresh error only comes from a refresh
   a_r3_err_needs_refresh: assert property (@(posedge clk) disable iff (!rst_n)
      flt_re |-> refresh_p);
   // R5: at most one fault output at a time
   a_r5_one_output: assert property (@(posedge clk) disable iff (!rst_n)
      !(rst_o && nmi_o));
   // R6: a stopped counter reads zero
   a_r6_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_HOLD) |-> (cnt_q == '0));
   // R6: register-start idle waits for a refresh
   a_r6_idle_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (!auto_mode && st_q == ST_IDLE && !refresh_p) |=> (st_q == ST_IDLE && cnt_q == '0));
endmodule

// File: rtl/winwdog.sv
`timescale 1ns/1ps
module winwdog
   import wdg_pkg::*;
#(
   parameter int unsigned CNT_W  = 14,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned DIV0   = 1,
   parameter int unsigned DIV1   = 4,
   parameter int unsigned DIV2   = 16,
   parameter int unsigned DIV3   = 64,
   parameter bit          HAS_PRESCALER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              opt_auto,
   input  logic [7:0]        opt_cfg,
   input  logic              opt_rst_sel,
   output logic              wdt_rst_o,
   output logic              wdt_nmi_o
);
   initial begin
      assert (CNT_W >= 6) else $fatal(1, "counter too narrow");
      assert (DATA_W >= CNT_W + 2 && DATA_W >= 8) else $fatal(1, "data path too narrow");
   end

   wdg_cfg_t         reg_cfg, eff_cfg;
   logic             reg_rsel, eff_rsel;
   logic             tick, restart, refresh_p, flt_uf, flt_re, lock_clr;
   logic [CNT_W-1:0] cnt;

   assign eff_cfg  = opt_auto ? wdg_cfg_t'(opt_cfg) : reg_cfg;
   assign eff_rsel = opt_auto ? opt_rst_sel : reg_rsel;

   wdg_prescale #(.DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3),
                  .HAS_PRESCALER(HAS_PRESCALER)) u_pre (
      .clk(clk), .rst_n(rst_n), .restart(restart), .sel(eff_cfg.cks), .tick(tick));

   wdg_refresh u_ref (
      .clk(clk), .rst_n(rst_n),
      .wr_en(bus_we && bus_addr == ADDR_REFRESH),
      .wdata(bus_wdata[7:0]), .refresh_p(refresh_p));

   wdg_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .auto_mode(opt_auto),
      .refresh_p(refresh_p), .lock_clr(lock_clr), .flt_uf(flt_uf), .flt_re(flt_re),
      .cnt(cnt), .reg_cfg(reg_cfg), .reg_rsel(reg_rsel));

   wdg_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .auto_mode(opt_auto), .tick(tick),
      .refresh_p(refresh_p), .tops_i(eff_cfg.tops), .wstart_i(eff_cfg.wstart),
      .wend_i(eff_cfg.wend), .rst_sel(eff_rsel), .cnt(cnt), .restart(restart),
      .flt_uf(flt_uf), .flt_re(flt_re), .lock_clr(lock_clr),
      .rst_o(wdt_rst_o), .nmi_o(wdt_nmi_o));
endmodule

// File: tb/winwdog_tb_top.sv
`timescale 1ns/1ps
module winwdog_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [1:0]  bus_addr = 2'd3;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        opt_auto = 1'b0;
   logic [7:0]  opt_cfg = '0;
   logic        opt_rst_sel = 1'b0;
   logic        wdt_rst_o, wdt_nmi_o;

   int vecs = 0;
   int errs = 0;
   int cyc  = 0;
   bit done = 1'b0;

   winwdog #(.CNT_W(14), .DATA_W(16), .DIV0(1), .DIV1(2), .DIV2(4), .DIV3(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .opt_auto(opt_auto),
      .opt_cfg(opt_cfg), .opt_rst_sel(opt_rst_sel),
      .wdt_rst_o(wdt_rst_o), .wdt_nmi_o(wdt_nmi_o));

   always #2 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 190000 && !done) begin
         done = 1'b1;
         errs = errs + 1;
         $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      vecs = vecs + 1;
      if (act != exp) begin
         errs = errs + 1;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic sys_reset();
      @(negedge clk);
      rst_n = 1'b0; bus_we = 1'b0; bus_addr = 2'd3;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; bus_addr = 2'd3;
   endtask

   task automatic do_refresh();
      wr(2'd0, 16'h0000);
      wr(2'd0, 16'h00FF);
      @(negedge clk);
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] v);
      bus_addr = a;
      #0.5;
      v = bus_rdata;
      bus_addr = 2'd3;
      #0.5;
   endtask

   task automatic wait_fault(output int k);
      k = 0;
      while (!(wdt_rst_o || wdt_nmi_o) && k < 40000) begin
         @(negedge clk);
         k = k + 1;
      end
   endtask

   logic [15:0] s;
   int k, w;

   initial begin
      // R11 reset state
      sys_reset();
      repeat (2) @(negedge clk);
      rd(2'd3, s); chk("R11 status", s, 0);
      rd(2'd1, s); chk("R11 ctrl", s, 0);
      rd(2'd2, s); chk("R11 rctrl", s, 0);
      chk("R11 rst_o", wdt_rst_o, 0);
      chk("R11 nmi_o", wdt_nmi_o, 0);

      // R9 refresh sequence
      wr(2'd0, 16'h0000); wr(2'd0, 16'h0055); wr(2'd0, 16'h00FF);
      repeat (3) @(negedge clk);
      rd(2'd3, s); chk("R9 broken sequence", s[13:0], 0);
      wr(2'd0, 16'h00FF);
      repeat (3) @(negedge clk);
      rd(2'd3, s); chk("R9 lone FF", s[13:0], 0);
      do_refresh();
      rd(2'd3, s); chk("R9 valid refresh R6 load", s[13:0], 1023);

      // R1 time-out sweep, R2 ratio sweep
      for (int t = 0; t < 4; t++) begin
         sys_reset();
         wr(2'd1, 16'(t));
         do_refresh();
         wait_fault(k);
         chk($sformatf("R1 timeout code %0d", t), k, 1024 << ((t == 0) ? 0 : t + 1));
         chk("R5 nmi selected no rst", wdt_rst_o, 0);
         @(negedge clk);
         chk("R5 nmi one clock", wdt_nmi_o, 0);
         rd(2'd3, s); chk("R4 underflow flag", s[14], 1);
      end
      for (int c = 1; c < 4; c += 2) begin
         sys_reset();
         wr(2'd1, 16'(c << 2));
         do_refresh();
         wait_fault(k);
         chk($sformatf("R2 ratio code %0d", c), k, 1024 * (1 << c));
      end

      // R5 reset output width at ratio 4
      sys_reset();
      wr(2'd1, 16'h0008);
      wr(2'd2, 16'h0001);
      do_refresh();
      wait_fault(k);
      chk("R2 ratio 4 timeout", k, 4096);
      chk("R5 nmi low in reset select", wdt_nmi_o, 0);
      w = 0;
      while (wdt_rst_o && w < 100) begin
         @(negedge clk); w = w + 1;
      end
      chk("R5 reset width one count", w, 4);

      // R6 register-start stays stopped after fault
      sys_reset();
      do_refresh();
      wait_fault(k);
      k = 0;
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (wdt_nmi_o || wdt_rst_o) k = k + 1;
      end
      rd(2'd3, s);
      chk("R6 counter stopped at zero", s[13:0], 0);
      chk("R6 no further fault", k, 0);
      do_refresh();
      rd(2'd3, s); chk("R6 restart on refresh", s[13:0], 1023);

      // R8 write-once and lock release
      sys_reset();
      wr(2'd1, 16'h0001); wr(2'd1, 16'h0002);
      rd(2'd1, s); chk("R8 single write", s, 1);
      sys_reset();
      wr(2'd2, 16'h0001);
      wr(2'd2, 16'h0000);
      rd(2'd2, s); chk("R8 rctrl single write", s, 1);
      do_refresh();
      wr(2'd1, 16'h0002);
      rd(2'd1, s); chk("R8 refresh locks ctrl", s, 0);
      wait_fault(k);
      chk("R5 reset output", wdt_rst_o, 1);
      repeat (2) @(negedge clk);
      wr(2'd1, 16'h0003);
      rd(2'd1, s); chk("R8 lock cleared by own reset", s, 3);
      wr(2'd2, 16'h0000);
      rd(2'd2, s); chk("R8 rctrl unlocked", s, 0);

      // R10 status flags
      sys_reset();
      wr(2'd1, 16'h00C0);
      do_refresh();
      do_refresh();
      rd(2'd3, s);
      chk("R3 early refresh error flag", s[15], 1);
      chk("R10 underflow clear on error", s[14], 0);
      wr(2'd3, 16'hFFFF);
      rd(2'd3, s); chk("R10 write one keeps", s[15], 1);
      do_refresh();
      wait_fault(k);
      @(negedge clk);
      rd(2'd3, s);
      chk("R10 replace uf set", s[14], 1);
      chk("R10 replace re cleared", s[15], 0);
      wr(2'd3, 16'hBFFF);
      rd(2'd3, s); chk("R10 clear uf by zero", s[14], 0);
      do_refresh();
      do_refresh();
      rd(2'd3, s); chk("R10 error again", s[15], 1);
      wr(2'd3, 16'h7FFF);
      rd(2'd3, s); chk("R10 clear re by zero", s[15], 0);

      // R3 window sweep over all start/end codes
      for (int ws = 0; ws < 4; ws++) begin
         for (int we = 0; we < 4; we++) begin
            for (int vi = 0; vi < 4; vi++) begin
               int sl, el, v, ok, guard;
               sl = 256 * (ws + 1);
               el = 256 * (3 - we);
               case (vi)
                  0: v = (sl - 1 > 1021) ? 1021 : sl - 1;
                  1: v = sl;
                  2: v = el;
                  default: v = el - 1;
               endcase
               if (v >= 0 && v <= 1021) begin
                  ok = (v < sl && v >= el) ? 1 : 0;
                  sys_reset();
                  wr(2'd1, 16'((we << 6) | (ws << 4)));
                  do_refresh();
                  guard = 0;
                  rd(2'd3, s);
                  while (int'(s[13:0]) != v + 2 && guard < 2000) begin
                     @(negedge clk);
                     rd(2'd3, s);
                     guard = guard + 1;
                  end
                  do_refresh();
                  rd(2'd3, s);
                  chk($sformatf("R3 ws%0d we%0d cnt%0d error flag", ws, we, v), s[15], 1 - ok);
                  chk($sformatf("R3 ws%0d we%0d cnt%0d counter", ws, we, v), s[13:0], ok ? 1023 : 0);
               end
            end
         end
      end

      // R7 auto-start
      opt_auto = 1'b1; opt_cfg = 8'hF0; opt_rst_sel = 1'b0;
      sys_reset();
      wait_fault(k);
      chk("R7 first fault from release", k, 1025);
      @(negedge clk);
      wait_fault(k);
      chk("R7 automatic restart gap", k + 1, 1025);
      wr(2'd1, 16'h0003);
      rd(2'd1, s); chk("R7 ctrl ignored", s, 0);
      opt_auto = 1'b0;

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule